// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is a synchronous I2C slave that lets a bus master reach a small bank of 8-bit registers. It watches SCL and SDA, which arrive already synchronized to the system clock. It finds START, repeated START and STOP conditions, and it answers to a 7-bit address. The upper four bits of that address are fixed by a parameter, and the lower three come from strap pins. It pulls SDA low to acknowledge. SDA is handled as an open-drain line: the block only ever drives it low, through an output enable.

In a write transaction, the first byte after the address is a command byte, and the block stores it as the register pointer. Every later byte in the same write goes to the register the pointer selects. A read transaction sends that same register again and again for as long as the master keeps acknowledging. The pointer never advances by itself. It stays in place across transactions until a new command byte arrives, so a write of the command byte, a repeated START and a read together form a normal register fetch.

The register bank sits outside this block. The block reaches it through a one-cycle write strobe, a one-cycle read strobe, the pointer, the write data byte and a returned read data byte. The block decides which accesses reach the bank: register 0 is read-only, and command values that name no register are dropped on write and read back as zero.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After reset, SDA is released (sda_oe_o = 0), both strobes are low, the pointer is 0 and the block waits for a START.
- R2: The slave answers to the 7-bit address {NIB, strap_i[2:0]}. NIB is 4'b0100 when ALT_ADDR = 0 and 4'b0111 when ALT_ADDR = 1. The address is sent MSB first, and the bit after it is the direction bit (0 = write, 1 = read). On a match the slave pulls SDA low through the ninth clock. On a mismatch it leaves SDA released for the rest of that transaction.
- R3: In a write, the first byte after the address is stored as the pointer and acknowledged, whatever its value. reg_ptr_o shows its low PTR_W bits.
- R4: Each later byte of a write is acknowledged and produces exactly one reg_wr_o pulse, with that byte on reg_wdata_o. All bytes go to the same pointed register; the pointer never increments.
- R5: A write to register 0, or to a pointer value of NUM_REGS or above, is acknowledged but produces no write strobe.
- R6: A read sends the pointed register MSB first and pulses reg_rd_o once per byte. The same register is sent again for each byte the master acknowledges. A pointer of NUM_REGS or above sends 0x00 and produces no read strobe.
- R7: After a master NACK, the slave releases SDA and sends nothing more until the next START.
- R8: A repeated START begins a new address phase. The pointer is kept across STOP, START and repeated START.
- R9: A STOP or START in the middle of a byte abandons that byte. A partly received byte is never written.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: Each strobe lasts one clock, the two strobes never coincide, and both occur only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| strap_i | input | 3 | Low three address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_o | output | 1 | One-cycle write strobe to the bank |
| reg_rd_o | output | 1 | One-cycle read strobe to the bank |
| reg_ptr_o | output | PTR_W | Selected register index |
| reg_wdata_o | output | 8 | Byte to write |
| reg_rdata_i | input | 8 | Contents of the selected register |

## Verification
The bound checker watches, on every cycle, that SDA drive changes only after SCL has been low, that the strobes are single, exclusive pulses issued with SCL low, that no write strobe ever names register 0, and that the block leaves reset with SDA released and the pointer at zero. Other behaviours depend on the whole bit sequence of a transaction, and only the bench scenarios can show them. These are address matching for both nibble variants, pointer persistence across transactions and repeated STARTs, the repeated sending of one register during a multi-byte read, the zero data from unmapped pointers, the silence after a NACK, and the dropping of bytes cut short by STOP or START.

// File: rtl/i2c_ptr_pkg.sv
// Shared constants and the bus state type for the I2C register-pointer slave.
// Assumes a byte-oriented bus with 7-bit addressing.
package i2c_ptr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] BYTE_DONE = 4'd8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_t;

endpackage

// File: rtl/i2c_line_mon.sv
// Line monitor: turns the synchronized SCL/SDA levels into single-cycle events.
// Events are SCL rising, SCL falling, START (SDA falls while SCL stays high)
// and STOP (SDA rises while SCL stays high).
// Assumes the inputs are already free of metastability and glitches.
module i2c_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Keep the previous line levels; an idle bus rests high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Compare old and new levels to form the bus events.
    always_comb begin
        scl_rise  = !scl_q && scl_i;
        scl_fall  = scl_q && !scl_i;
        start_det = scl_q && scl_i && sda_q && !sda_i;
        stop_det  = scl_q && scl_i && !sda_q && sda_i;
    end

endmodule

// File: rtl/i2c_ptr_fsm.sv
// Bus state machine: shifts in the address, command and data bytes, drives
// ACK and read data onto SDA, and raises single-cycle requests for command
// load, register write and register read.
// Assumes line events from i2c_line_mon. SDA drive is changed only on an
// SCL falling event.
module i2c_ptr_fsm
    import i2c_ptr_pkg::*;
#(
    parameter logic [3:0] ADDR_NIB = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              cmd_load,
    output logic              wr_req,
    output logic              rd_req,
    output logic [BYTE_W-1:0] rx_byte
);

    bus_state_t         state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  rx_sh;
    logic [BYTE_W-1:0]  tx_sh;
    logic               dir_rd;
    logic               master_ack;
    logic               addr_hit;
    logic               rx_phase;
    logic               byte_end;

    // Address comparison and byte-boundary decode.
    always_comb begin
        addr_hit = (rx_sh[BYTE_W-1:1] == {ADDR_NIB, strap_i});
        rx_phase = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);
        byte_end = scl_fall && (bit_cnt == BYTE_DONE);
    end

    // Request pulses toward the pointer/access gate.
    always_comb begin
        cmd_load = byte_end && (state == ST_CMD);
        wr_req   = byte_end && (state == ST_WDATA);
        rd_req   = scl_fall && (((state == ST_ADDR_ACK) && dir_rd) ||
                                ((state == ST_RDATA_ACK) && master_ack));
        rx_byte  = rx_sh;
    end

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            dir_rd     <= 1'b0;
            master_ack <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            if (rx_phase && scl_rise && (bit_cnt != BYTE_DONE)) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], sda_i};
                bit_cnt <= bit_cnt + 1'b1;
            end
            case (state)
                ST_ADDR: begin
                    if (byte_end) begin
                        bit_cnt <= '0;
                        if (addr_hit) begin
                            state  <= ST_ADDR_ACK;
                            dir_rd <= rx_sh[0];
                            sda_oe <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_CMD: begin
                    if (byte_end) begin
                        bit_cnt <= '0;
                        state   <= ST_CMD_ACK;
                        sda_oe  <= 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (byte_end) begin
                        bit_cnt <= '0;
                        state   <= ST_WDATA_ACK;
                        sda_oe  <= 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (dir_rd) begin
                            state  <= ST_RDATA;
                            tx_sh  <= tx_byte;
                            sda_oe <= !tx_byte[BYTE_W-1];
                        end else begin
                            state  <= ST_CMD;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        state  <= ST_WDATA;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_end) begin
                        bit_cnt <= '0;
                        state   <= ST_RDATA_ACK;
                        sda_oe  <= 1'b0;
                    end else if (scl_fall) begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= !tx_sh[BYTE_W-2];
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        master_ack <= !sda_i;
                    end
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (master_ack) begin
                            state  <= ST_RDATA;
                            tx_sh  <= tx_byte;
                            sda_oe <= !tx_byte[BYTE_W-1];
                        end else begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                default: begin
                    bit_cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_ptr_gate.sv
// Pointer register and access gate: holds the last command byte, decides
// whether a write or read request may reach the bank, and zeroes read data
// for pointers that name no register.
// Assumes that cmd_load, wr_req and rd_req never coincide.
module i2c_ptr_gate
    import i2c_ptr_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter logic [NUM_REGS-1:0] RO_MASK = 4'b0001,
    localparam int PTR_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_load,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [BYTE_W-1:0] bank_rdata,
    output logic [PTR_W-1:0]  reg_ptr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [BYTE_W-1:0] tx_byte
);

    localparam logic [BYTE_W-1:0] REG_LIMIT = BYTE_W'(NUM_REGS);

    logic [BYTE_W-1:0]   cmd_q;
    logic                ptr_valid;
    logic [NUM_REGS-1:0] writable;

    // Per-register write permission derived from the read-only mask.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_wperm
            assign writable[gi] = !RO_MASK[gi];
        end
    endgenerate

    // Command byte store; kept until a new command byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_load) begin
            cmd_q <= cmd_byte;
        end
    end

    // Access decode toward the bank and data selection toward the bus.
    always_comb begin
        ptr_valid = (cmd_q < REG_LIMIT);
        reg_ptr   = cmd_q[PTR_W-1:0];
        reg_wr    = wr_req && ptr_valid && writable[reg_ptr];
        reg_rd    = rd_req && ptr_valid;
        tx_byte   = ptr_valid ? bank_rdata : '0;
    end

endmodule

// File: rtl/i2c_ptr_slave.sv
// Top of the I2C register-pointer slave. It joins the line monitor, the bus
// state machine and the pointer/access gate.
// Assumes scl_i/sda_i are synchronized, and that sda_oe_o drives an
// open-drain pull-down outside this block.
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter bit ALT_ADDR = 1'b0,
    parameter int NUM_REGS = 4,
    parameter logic [NUM_REGS-1:0] RO_MASK = 4'b0001,
    localparam int PTR_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_oe_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [PTR_W-1:0]  reg_ptr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);

    localparam logic [3:0] ADDR_NIB = ALT_ADDR ? 4'b0111 : 4'b0100;

    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              cmd_load;
    logic              wr_req;
    logic              rd_req;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;

    i2c_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ptr_fsm #(
        .ADDR_NIB (ADDR_NIB)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_i     (sda_i),
        .strap_i   (strap_i),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe_o),
        .cmd_load  (cmd_load),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .rx_byte   (rx_byte)
    );

    i2c_ptr_gate #(
        .NUM_REGS (NUM_REGS),
        .RO_MASK  (RO_MASK)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_load   (cmd_load),
        .cmd_byte   (rx_byte),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .bank_rdata (reg_rdata_i),
        .reg_ptr    (reg_ptr_o),
        .reg_wr     (reg_wr_o),
        .reg_rd     (reg_rd_o),
        .tx_byte    (tx_byte)
    );

    // The write data is the byte just shifted in.
    assign reg_wdata_o = rx_byte;

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
// Checker for i2c_ptr_slave: properties over its ports, bound into every
// instance. Assumes register 0 is the read-only register.
module i2c_ptr_slave_chk #(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe_o,
    input logic             reg_wr_o,
    input logic             reg_rd_o,
    input logic [PTR_W-1:0] reg_ptr_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sda_oe_o && !reg_wr_o && !reg_rd_o && (reg_ptr_o == '0)));

    // R10
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_i));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));

    // R11
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    // R11
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);

    // R11
    strobe_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o || reg_rd_o) |-> !scl_i);

    // R5
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> (reg_ptr_o != '0));

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .reg_wr_o  (reg_wr_o),
    .reg_rd_o  (reg_rd_o),
    .reg_ptr_o (reg_ptr_o)
);

// File: tb/i2c_ptr_slave_bench.sv
// Bench for i2c_ptr_slave: bus master tasks, a bank model and a reference
// model of the registers and the pointer.
module i2c_ptr_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam logic [6:0] MAIN_ADDR = 7'b0100_010;
    localparam logic [6:0] ALT_DEV   = 7'b0111_101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;

    logic       sda_oe, sda_oe_alt;
    logic       reg_wr, reg_rd;
    logic [1:0] reg_ptr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       alt_wr, alt_rd;
    logic [1:0] alt_ptr;
    logic [7:0] alt_wdata;

    logic [7:0] bank [4];
    logic [7:0] m_regs [4];
    logic [7:0] m_ptr;
    logic [7:0] wbuf [4];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = !clk;

    assign sda_line  = sda_m && !sda_oe && !sda_oe_alt;
    assign reg_rdata = bank[reg_ptr];

    i2c_ptr_slave u_i2c_ptr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(3'b010), .sda_oe_o(sda_oe), .reg_wr_o(reg_wr),
        .reg_rd_o(reg_rd), .reg_ptr_o(reg_ptr), .reg_wdata_o(reg_wdata),
        .reg_rdata_i(reg_rdata)
    );

    i2c_ptr_slave #(.ALT_ADDR(1'b1)) u_i2c_ptr_slave_alt (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(3'b101), .sda_oe_o(sda_oe_alt), .reg_wr_o(alt_wr),
        .reg_rd_o(alt_rd), .reg_ptr_o(alt_ptr), .reg_wdata_o(alt_wdata),
        .reg_rdata_i(8'h3C)
    );

    // Bank model: it accepts any strobe, so a wrongly allowed write shows up.
    always @(posedge clk) begin
        if (!rst_n) begin
            bank[0] <= 8'hA5; bank[1] <= 8'h11; bank[2] <= 8'h22; bank[3] <= 8'h33;
        end else begin
            if (reg_wr) begin
                bank[reg_ptr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [7:0] p);
        return (p < 8'd4) ? m_regs[p[1:0]] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half_wait();
        scl = 1'b1;   half_wait();
        sda_m = 1'b0; half_wait();
        scl = 1'b0;   half_wait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half_wait();
        scl = 1'b1;   half_wait();
        sda_m = 1'b1; half_wait();
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; half_wait();
            scl = 1'b1;   half_wait();
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        put_bits(b, 8);
        sda_m = 1'b1; half_wait();
        scl = 1'b1;
        repeat (2) @(negedge clk);
        ack = !sda_line;
        repeat (HALF - 2) @(negedge clk);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            half_wait();
            scl = 1'b1;
            repeat (2) @(negedge clk);
            b[i] = sda_line;
            repeat (HALF - 2) @(negedge clk);
            scl = 1'b0;
        end
        sda_m = !mack; half_wait();
        scl = 1'b1;    half_wait();
        scl = 1'b0;    half_wait();
    endtask

    // Write transaction: command byte then n data bytes from wbuf (R3, R4, R5).
    task automatic wr_txn(input logic [7:0] cmd, input int n);
        bit ack;
        int w0 = wr_cnt;
        int expw = 0;
        bus_start();
        send_byte({MAIN_ADDR, 1'b0}, ack);
        chk(ack, "R2 address ack", ack, 1);
        send_byte(cmd, ack);
        chk(ack, "R3 command ack", ack, 1);
        m_ptr = cmd;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk(ack, "R4 data ack", ack, 1);
            if (cmd >= 8'd1 && cmd <= 8'd3) begin
                m_regs[cmd[1:0]] = wbuf[k];
                expw++;
            end
        end
        bus_stop();
        chk(wr_cnt - w0 == expw, "R4/R5 write strobe count", wr_cnt - w0, expw);
        chk(reg_ptr == cmd[1:0], "R3 pointer", reg_ptr, cmd[1:0]);
    endtask

    // Read transaction, optionally setting the pointer first via repeated START (R6, R8).
    task automatic rd_txn(input bit set_ptr, input logic [7:0] cmd, input int n);
        bit ack;
        logic [7:0] b;
        int r0;
        if (set_ptr) begin
            bus_start();
            send_byte({MAIN_ADDR, 1'b0}, ack);
            chk(ack, "R2 address ack", ack, 1);
            send_byte(cmd, ack);
            chk(ack, "R3 command ack", ack, 1);
            m_ptr = cmd;
        end
        r0 = rd_cnt;
        bus_start();
        send_byte({MAIN_ADDR, 1'b1}, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == exp_rd(m_ptr), "R6/R8 read data", b, exp_rd(m_ptr));
        end
        bus_stop();
        chk(rd_cnt - r0 == ((m_ptr < 8'd4) ? n : 0), "R6 read strobe count",
            rd_cnt - r0, (m_ptr < 8'd4) ? n : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int w0;
        int r0;
        int op;
        bit line_ok;
        m_regs[0] = 8'hA5; m_regs[1] = 8'h11; m_regs[2] = 8'h22; m_regs[3] = 8'h33;
        m_ptr = 8'h00;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: state right after reset
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        chk(!reg_wr && !reg_rd, "R1 strobes low", {reg_wr, reg_rd}, 0);
        chk(reg_ptr == 2'd0, "R1 pointer zero", reg_ptr, 0);

        // R4: two bytes to register 1, no auto-increment into register 2
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        wr_txn(8'h01, 2);
        rd_txn(1'b0, 8'h01, 1);
        rd_txn(1'b1, 8'h02, 1);

        // R5: write to the read-only register 0 is dropped
        wbuf[0] = 8'hFF;
        wr_txn(8'h00, 1);
        rd_txn(1'b0, 8'h00, 2);

        // R3/R5/R6: pointer beyond the bank
        wbuf[0] = 8'h77;
        wr_txn(8'h07, 1);
        rd_txn(1'b0, 8'h07, 2);

        // R6/R8: multi-byte read of register 3 after a repeated START
        rd_txn(1'b1, 8'h03, 3);

        // R7: after NACK the slave stays silent through further clocks
        bus_start();
        send_byte({MAIN_ADDR, 1'b1}, ack);
        recv_byte(1'b0, b);
        chk(b == m_regs[3], "R7 data before NACK", b, m_regs[3]);
        r0 = rd_cnt;
        line_ok = 1'b1;
        for (int i = 0; i < 9; i++) begin
            half_wait(); scl = 1'b1;
            repeat (2) @(negedge clk);
            if (!sda_line) line_ok = 1'b0;
            repeat (HALF - 2) @(negedge clk);
            scl = 1'b0;
        end
        chk(line_ok, "R7 sda released after NACK", line_ok, 1);
        chk(rd_cnt == r0, "R7 no read after NACK", rd_cnt - r0, 0);
        bus_stop();

        // R9: STOP in the middle of a data byte
        w0 = wr_cnt;
        bus_start();
        send_byte({MAIN_ADDR, 1'b0}, ack);
        send_byte(8'h03, ack);
        m_ptr = 8'h03;
        put_bits(8'h99, 3);
        bus_stop();
        chk(wr_cnt == w0, "R9 partial byte dropped on STOP", wr_cnt - w0, 0);
        rd_txn(1'b0, 8'h03, 1);

        // R9/R8: START in the middle of a data byte, pointer kept
        w0 = wr_cnt;
        bus_start();
        send_byte({MAIN_ADDR, 1'b0}, ack);
        send_byte(8'h02, ack);
        m_ptr = 8'h02;
        put_bits(8'hEE, 5);
        bus_start();
        send_byte({MAIN_ADDR, 1'b1}, ack);
        chk(ack, "R8 ack after mid-byte START", ack, 1);
        recv_byte(1'b0, b);
        chk(b == m_regs[2], "R9 register unchanged", b, m_regs[2]);
        bus_stop();
        chk(wr_cnt == w0, "R9 partial byte dropped on START", wr_cnt - w0, 0);

        // R2: mismatched address is ignored
        w0 = wr_cnt;
        bus_start();
        send_byte({7'b0100_011, 1'b0}, ack);
        chk(!ack, "R2 wrong strap not acked", ack, 0);
        send_byte(8'h01, ack);
        chk(!ack, "R2 no ack after mismatch", ack, 0);
        bus_stop();
        chk(wr_cnt == w0, "R2 no write after mismatch", wr_cnt - w0, 0);

        // R2: alternate nibble variant responds, main one does not
        bus_start();
        send_byte({ALT_DEV, 1'b1}, ack);
        chk(ack, "R2 alternate nibble ack", ack, 1);
        recv_byte(1'b0, b);
        chk(b == 8'h3C, "R2 alternate read data", b, 8'h3C);
        bus_stop();
        bus_start();
        send_byte({7'b0111_010, 1'b0}, ack);
        chk(!ack, "R2 nibble 0111 with main strap unacked", ack, 0);
        bus_stop();

        // Random mix of writes and reads (R3..R6, R8)
        for (int it = 0; it < 40; it++) begin
            op = int'($urandom % 3);
            if (op == 0) begin
                for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
                wr_txn(8'($urandom % 6), 1 + int'($urandom % 3));
            end else if (op == 1) begin
                rd_txn(1'b1, 8'($urandom % 6), 1 + int'($urandom % 3));
            end else begin
                rd_txn(1'b0, m_ptr, 1 + int'($urandom % 3));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule